// File: doc/BRIEF.md
# Run-time Partitioned Byte-Lane Equality Comparator

This block compares two wide operands and reports equality per group of byte lanes, where the grouping is chosen on every evaluation by a vector of split bits. Each split bit cuts the operand between two neighbouring byte lanes. The lanes between two cuts form one partition. A partition reports "equal" only when every bit it covers matches. That single answer is then written to every output bit that belongs to the partition, so a consumer can read the result of any lane and get the verdict of the whole partition around it.

The block is purely combinational. An opcode input chooses the kind of comparison. Only equality produces a result. The ordering comparisons are decoded but give an all-zero output, and so does the reserved code. A SIMD datapath can use one instance to compare one 64-bit value, two 32-bit values, eight bytes, or any mix of contiguous byte groups.

Top module: `part_eq_cmp`

## Requirements
- R1: The operands hold LANES byte lanes of LANE_W bits (8 by 8 by default). Lane i covers bits [i*LANE_W +: LANE_W], and output bit i belongs to lane i.
- R2: When split bit i is 1, lanes i and i+1 fall in different partitions. When it is 0, they fall in the same partition.
- R3: A partition covering lanes p to p+w-1 gives 1 exactly when a and b agree on all bits [p*LANE_W +: w*LANE_W]. A single differing bit anywhere in the partition makes it 0.
- R4: Every output bit from lane p to lane p+w-1 carries the same value, which is the result of that partition.
- R5: With all split bits 0, every output bit equals the full-width comparison a == b.
- R6: With all split bits 1, output bit i is the equality of lane i alone.
- R7: The opcode is 2 bits wide: 2'b00 selects equality, 2'b01 greater-than, 2'b10 greater-or-equal, and 2'b11 is reserved. Any code other than 2'b00 drives the output to all zeros.
- R8: The output follows the inputs combinationally, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| split | input | 7 | Bit i cuts between lane i and lane i+1 |
| opcode | input | 2 | Comparison selector (2'b00 is equality) |
| result | output | 8 | Per-lane partition result |

## Verification
The bench builds the block with its defaults: eight lanes of eight bits. At that size all 128 split patterns can be covered. For every pattern, the bench applies equal operands, random operands, and operands that differ in exactly one byte at each of the eight lane positions. A one-byte difference has to clear exactly the partition that contains it and leave every other partition at 1, so all partition widths and offsets are checked at both of their edges. The three non-equality opcodes are also applied with identical operands, where the equality result would otherwise be all ones.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int OP_W = 2;
  localparam logic [OP_W-1:0] OP_EQ  = 2'b00;
  localparam logic [OP_W-1:0] OP_GT  = 2'b01;
  localparam logic [OP_W-1:0] OP_GE  = 2'b10;
  localparam logic [OP_W-1:0] OP_RSV = 2'b11;
endpackage

// File: rtl/cmp_lane_eq.sv
// Per-lane equality: one bit per byte lane (R1).
module cmp_lane_eq #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [LANES-1:0]  lane_eq
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_eq[i] = (a[i*LANE_W +: LANE_W] == b[i*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/cmp_seg_reduce.sv
// AND-reduce lane bits within each partition and spread the result (R2-R4).
// The forward chain holds the AND from the partition start up to lane i.
// The backward chain holds the AND from lane i up to the partition end.
// Their product is the AND over the whole partition.
module cmp_seg_reduce #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] lane_eq,
  input  logic [LANES-2:0] split,
  output logic [LANES-1:0] seg_eq
);
  logic [LANES-1:0] fwd;
  logic [LANES-1:0] bwd;

  always_comb begin
    fwd[0] = lane_eq[0];
    for (int i = 1; i < LANES; i++) begin
      fwd[i] = lane_eq[i] & (split[i-1] | fwd[i-1]);
    end
  end

  always_comb begin
    bwd[LANES-1] = lane_eq[LANES-1];
    for (int i = LANES - 2; i >= 0; i--) begin
      bwd[i] = lane_eq[i] & (split[i] | bwd[i+1]);
    end
  end

  assign seg_eq = fwd & bwd;
endmodule

// File: rtl/cmp_op_mask.sv
// Opcode decode: only equality passes the partition result (R7).
module cmp_op_mask
  import cmp_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [OP_W-1:0]  opcode,
  input  logic [LANES-1:0] seg_eq,
  output logic [LANES-1:0] result
);
  always_comb begin
    unique case (opcode)
      OP_EQ:   result = seg_eq;
      OP_GT,
      OP_GE,
      OP_RSV:  result = '0;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/part_eq_cmp.sv
// Run-time partitioned equality comparator, combinational (R8).
module part_eq_cmp
  import cmp_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [LANES-2:0]  split,
  input  logic [OP_W-1:0]   opcode,
  output logic [LANES-1:0]  result
);
  logic [LANES-1:0] lane_eq;
  logic [LANES-1:0] seg_eq;

  cmp_lane_eq #(.LANES(LANES), .LANE_W(LANE_W)) u_lane (
    .a       (a),
    .b       (b),
    .lane_eq (lane_eq)
  );

  cmp_seg_reduce #(.LANES(LANES)) u_seg (
    .lane_eq (lane_eq),
    .split   (split),
    .seg_eq  (seg_eq)
  );

  cmp_op_mask #(.LANES(LANES)) u_mask (
    .opcode  (opcode),
    .seg_eq  (seg_eq),
    .result  (result)
  );
endmodule

module part_eq_cmp_chk
  import cmp_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic [LANES-2:0]  split,
  input logic [OP_W-1:0]   opcode,
  input logic [LANES-1:0]  result
);
  logic [LANES-1:0] byte_same;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      byte_same[i] = (a[i*LANE_W +: LANE_W] == b[i*LANE_W +: LANE_W]);
    end
  end

  always_comb begin
    // R7
    bad_op_zero_chk: assert (opcode == OP_EQ || result == '0);
    for (int i = 0; i < LANES; i++) begin
      // R3
      lane_mismatch_chk: assert (byte_same[i] || !result[i]);
    end
    for (int i = 0; i < LANES - 1; i++) begin
      // R4
      link_same_chk: assert (opcode != OP_EQ || split[i] || result[i] == result[i+1]);
    end
    // R5
    full_width_chk: assert (opcode != OP_EQ || split != '0 || result == {LANES{a == b}});
    // R6
    split_all_chk: assert (opcode != OP_EQ || split != '1 || result == byte_same);
  end
endmodule

bind part_eq_cmp part_eq_cmp_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .a      (a),
  .b      (b),
  .split  (split),
  .opcode (opcode),
  .result (result)
);

// File: tb/part_eq_cmp_test.sv
`timescale 1ns/1ps
module part_eq_cmp_test;
  localparam int LANES  = 8;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef struct {
    logic [LANES-1:0] exp;
    string            tag;
  } item_t;

  logic clk;
  logic rst_n;
  logic [DATA_W-1:0] a, b;
  logic [LANES-2:0]  split;
  logic [1:0]        opcode;
  logic [LANES-1:0]  result;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  part_eq_cmp #(.LANES(LANES), .LANE_W(LANE_W)) uut (
    .a(a), .b(b), .split(split), .opcode(opcode), .result(result)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // Reference: walk the lanes and close a partition at each cut (R1, R2, R3, R4)
  function automatic logic [LANES-1:0] model(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y,
                                             logic [LANES-2:0] s, logic [1:0] op);
    logic [LANES-1:0] r;
    int start;
    bit ok;
    r = '0;
    if (op != 2'b00) return r;  // R7
    start = 0;
    for (int i = 0; i < LANES; i++) begin
      if (i == LANES - 1 || s[i]) begin
        ok = 1;
        for (int j = start; j <= i; j++)
          if (x[j*LANE_W +: LANE_W] !== y[j*LANE_W +: LANE_W]) ok = 0;
        for (int j = start; j <= i; j++) r[j] = ok;
        start = i + 1;
      end
    end
    return r;
  endfunction

  task automatic drive(logic [DATA_W-1:0] x, logic [DATA_W-1:0] y,
                       logic [LANES-2:0] s, logic [1:0] op, string tag);
    item_t it;
    @(posedge clk);
    a = x; b = y; split = s; opcode = op;
    it.exp = model(x, y, s, op);
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: the output is combinational (R8), so it is compared at the next falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (result !== it.exp) begin
        errors++;
        $display("FAIL %s: split=%b op=%b result=%b expected=%b",
                 it.tag, split, opcode, result, it.exp);
      end
    end
  end

  function automatic string tag_for(logic [LANES-2:0] s);
    if (s == '0) return "R5";
    if (s == '1) return "R6";
    return "R3";
  endfunction

  initial begin
    a = '0; b = '0; split = '0; opcode = 2'b00;
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // Idle state: zero operands are equal, so every lane reads 1 (R8)
    drive('0, '0, '0, 2'b00, "R8");
    for (int g = 0; g < (1 << (LANES - 1)); g++) begin
      logic [DATA_W-1:0] x;
      logic [DATA_W-1:0] y;
      x = {$urandom, $urandom};
      drive(x, x, g[LANES-2:0], 2'b00, "R4");
      y = {$urandom, $urandom};
      drive(x, y, g[LANES-2:0], 2'b00, tag_for(g[LANES-2:0]));
      for (int l = 0; l < LANES; l++) begin
        logic [LANE_W-1:0] d;
        d = LANE_W'(($urandom % 255) + 1);
        y = x ^ (DATA_W'(d) << (l * LANE_W));
        // R1 R2: a single differing byte clears only its own partition
        drive(x, y, g[LANES-2:0], 2'b00, tag_for(g[LANES-2:0]));
      end
    end
    // R7: non-equality codes give zero even for identical operands
    for (int op = 1; op < 4; op++) begin
      logic [DATA_W-1:0] x;
      x = {$urandom, $urandom};
      drive(x, x, '0, 2'(op), "R7");
      drive(x, x, '1, 2'(op), "R7");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule